// File: doc/BRIEF.md
# Stage-1 Permission Overlay Evaluator

This block takes the read, write and execute rights that a stage-1 translation walk has already worked out for a page and narrows them with a permission overlay. The overlay is a per-page index that picks one 4-bit field out of an overlay register. The privileged class and the unprivileged class are each narrowed separately. Which overlay register serves each class depends on the translation regime. Whether a class may be narrowed at all depends on its overlay enable and on the permission model in use. The model is either rights encoded directly in the descriptor or a 4-bit indirect permission value.

After the overlay step, the privileged-access-never rule is applied: privileged write is withdrawn when user code can still reach the page. The block accepts one request per valid/ready handshake. It presents the refined rights one cycle later on a registered output port, with its own valid/ready pair, and holds that result until the consumer accepts it.

Permission vectors on every port use bit 0 for read, bit 1 for write and bit 2 for execute.

Top module: `s1_overlay_eval`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: A request is captured on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high right after that edge.
- R3: Under the direct permission model (`indirect` = 0), a class is overlay-capable exactly when its overlay enable is set.
- R4: Under the indirect model (`indirect` = 1), a class is overlay-capable only when its enable is set and its 4-bit indirect value is below 8.
- R5: Index n (`po_index`, 3 bits) selects overlay field n at register bits 4n+3 down to 4n. In that field, bit 0 grants read, bit 1 grants execute and bit 2 grants write.
- R6: The privileged register is EL1 when `regime` = 0 and EL2 when `regime` = 1, 2 or 3. The unprivileged register is EL0 when `regime` = 0 or 1. When `regime` = 2 or 3, the unprivileged overlay value is zero.
- R7: An overlay field with bit 3 set grants nothing.
- R8: Overlays only remove rights. For each overlay-capable class, each right is the AND of the base right and the matching overlay grant. An output right is never set unless the base right is set.
- R9: When neither overlay enable is set, the base rights pass through unchanged, subject only to R10.
- R10: After the overlay step, if `pan_en` is set and the unprivileged class still has read or write, privileged write is cleared. The same happens if the unprivileged class has execute while `pan_ext_en` is set.
- R11: While `out_valid` is high and `out_ready` is low, the output data stays stable and `in_ready` is low. Inputs offered in that time are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| indirect | input | 1 | 1 = indirect permission model, 0 = direct |
| priv_ind_val | input | 4 | Privileged indirect permission value |
| unpriv_ind_val | input | 4 | Unprivileged indirect permission value |
| base_priv | input | 3 | Privileged base rights {x,w,r} |
| base_unpriv | input | 3 | Unprivileged base rights {x,w,r} |
| po_index | input | 3 | Overlay index from the leaf descriptor |
| regime | input | 2 | 0 EL1&0, 1 EL2&0, 2/3 EL2 only |
| priv_ov_en | input | 1 | Privileged overlay enable |
| unpriv_ov_en | input | 1 | Unprivileged overlay enable |
| ov_reg_el0 | input | 64 | EL0 overlay register |
| ov_reg_el1 | input | 64 | EL1 overlay register |
| ov_reg_el2 | input | 64 | EL2 overlay register |
| pan_en | input | 1 | Privileged-access-never active |
| pan_ext_en | input | 1 | Extended mode: unprivileged execute also triggers |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_priv | output | 3 | Refined privileged rights {x,w,r} |
| out_unpriv | output | 3 | Refined unprivileged rights {x,w,r} |

## Verification
The bench targets the field-bit remap, since overlay bit 1 means execute while output bit 1 means write. A design that copied the field straight across would swap write and execute. It also drives the indirect value 7 against 8 to catch an eligibility test off by one. It covers regimes 2 and 3 to catch a design that still lets the EL0 register narrow user rights there. The privileged-access-never vectors are ordered so that an overlay which has already removed all user rights must suppress the write clear. A design that applied that rule before the overlay would wrongly drop privileged write. A stalled-output test changes the offered inputs and confirms that nothing moves until the result is accepted.

// File: rtl/s1ov_pkg.sv
package s1ov_pkg;

    // Permission vector layout shared by all ports: bit0 read, bit1 write, bit2 execute.
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef enum logic [1:0] {
        RG_EL10    = 2'd0,
        RG_EL20    = 2'd1,
        RG_EL2     = 2'd2,
        RG_EL2_ALT = 2'd3
    } regime_e;

    localparam int NCLASS = 2;
    localparam int CL_PRIV   = 0;
    localparam int CL_UNPRIV = 1;

    typedef struct packed {
        logic  vld;
        perm_t priv;
        perm_t unpriv;
    } result_t;

endpackage

// File: rtl/s1ov_field.sv
module s1ov_field
    import s1ov_pkg::*;
#(
    parameter int REG_W   = 64,
    parameter int FIELD_W = 4,
    parameter int IDX_W   = 3
) (
    input  logic [REG_W-1:0] ov_reg_i,
    input  logic [IDX_W-1:0] idx_i,
    output perm_t            grant_o
);
    // Overlay field layout: bit0 read, bit1 execute, bit2 write, others reserved.
    localparam logic [FIELD_W-1:0] USED_MASK = FIELD_W'(3'b111);

    logic [FIELD_W-1:0] field;
    logic               field_ok;

    always_comb begin
        field    = ov_reg_i[int'(idx_i)*FIELD_W +: FIELD_W];
        field_ok = (field & ~USED_MASK) == '0;
        grant_o  = '0;
        if (field_ok) begin
            grant_o.r = field[0];
            grant_o.x = field[1];
            grant_o.w = field[2];
        end
    end

endmodule

// File: rtl/s1ov_capable.sv
module s1ov_capable #(
    parameter int IND_W     = 4,
    parameter int IND_LIMIT = 8
) (
    input  logic             indirect_i,
    input  logic             enable_i,
    input  logic [IND_W-1:0] ind_val_i,
    output logic             capable_o
);
    localparam logic [IND_W-1:0] LIMIT_V = IND_W'(IND_LIMIT);

    always_comb begin
        if (indirect_i) begin
            capable_o = enable_i && (ind_val_i < LIMIT_V);
        end else begin
            capable_o = enable_i;
        end
    end

endmodule

// File: rtl/s1ov_mask.sv
module s1ov_mask
    import s1ov_pkg::*;
(
    input  perm_t base_i,
    input  perm_t grant_i,
    input  logic  apply_i,
    output perm_t perm_o
);
    always_comb begin
        perm_o = base_i;
        if (apply_i) begin
            perm_o.r = base_i.r & grant_i.r;
            perm_o.w = base_i.w & grant_i.w;
            perm_o.x = base_i.x & grant_i.x;
        end
    end

endmodule

// File: rtl/s1_overlay_eval.sv
module s1_overlay_eval
    import s1ov_pkg::*;
#(
    parameter int REG_W     = 64,
    parameter int FIELD_W   = 4,
    parameter int IDX_W     = 3,
    parameter int IND_W     = 4,
    parameter int IND_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             indirect,
    input  logic [IND_W-1:0] priv_ind_val,
    input  logic [IND_W-1:0] unpriv_ind_val,
    input  logic [2:0]       base_priv,
    input  logic [2:0]       base_unpriv,
    input  logic [IDX_W-1:0] po_index,
    input  logic [1:0]       regime,
    input  logic             priv_ov_en,
    input  logic             unpriv_ov_en,
    input  logic [REG_W-1:0] ov_reg_el0,
    input  logic [REG_W-1:0] ov_reg_el1,
    input  logic [REG_W-1:0] ov_reg_el2,
    input  logic             pan_en,
    input  logic             pan_ext_en,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_priv,
    output logic [2:0]       out_unpriv
);

    result_t st_d, st_q;

    logic [REG_W-1:0] sel_reg  [NCLASS];
    logic [IND_W-1:0] ind_val  [NCLASS];
    logic             ov_en    [NCLASS];
    perm_t            base     [NCLASS];
    perm_t            grant    [NCLASS];
    logic             capable  [NCLASS];
    logic             apply    [NCLASS];
    perm_t            masked   [NCLASS];

    logic    accept;
    logic    any_ov;
    logic    pan_hit;
    regime_e rg;

    // Register choice per regime
    always_comb begin
        rg = regime_e'(regime);
        unique case (rg)
            RG_EL10: begin
                sel_reg[CL_PRIV]   = ov_reg_el1;
                sel_reg[CL_UNPRIV] = ov_reg_el0;
            end
            RG_EL20: begin
                sel_reg[CL_PRIV]   = ov_reg_el2;
                sel_reg[CL_UNPRIV] = ov_reg_el0;
            end
            default: begin
                sel_reg[CL_PRIV]   = ov_reg_el2;
                sel_reg[CL_UNPRIV] = '0;
            end
        endcase
    end

    assign ind_val[CL_PRIV]   = priv_ind_val;
    assign ind_val[CL_UNPRIV] = unpriv_ind_val;
    assign ov_en[CL_PRIV]     = priv_ov_en;
    assign ov_en[CL_UNPRIV]   = unpriv_ov_en;
    assign base[CL_PRIV]      = perm_t'(base_priv);
    assign base[CL_UNPRIV]    = perm_t'(base_unpriv);
    assign any_ov             = priv_ov_en | unpriv_ov_en;

    for (genvar c = 0; c < NCLASS; c++) begin : g_class
        s1ov_field #(
            .REG_W   (REG_W),
            .FIELD_W (FIELD_W),
            .IDX_W   (IDX_W)
        ) u_field (
            .ov_reg_i (sel_reg[c]),
            .idx_i    (po_index),
            .grant_o  (grant[c])
        );

        s1ov_capable #(
            .IND_W     (IND_W),
            .IND_LIMIT (IND_LIMIT)
        ) u_capable (
            .indirect_i (indirect),
            .enable_i   (ov_en[c]),
            .ind_val_i  (ind_val[c]),
            .capable_o  (capable[c])
        );

        assign apply[c] = any_ov && ov_en[c] && capable[c];

        s1ov_mask u_mask (
            .base_i  (base[c]),
            .grant_i (grant[c]),
            .apply_i (apply[c]),
            .perm_o  (masked[c])
        );
    end

    assign accept = in_valid && in_ready;

    // Next-state computation
    always_comb begin
        st_d    = st_q;
        pan_hit = pan_en && (masked[CL_UNPRIV].r || masked[CL_UNPRIV].w ||
                             (pan_ext_en && masked[CL_UNPRIV].x));
        if (accept) begin
            st_d.vld    = 1'b1;
            st_d.priv   = masked[CL_PRIV];
            st_d.unpriv = masked[CL_UNPRIV];
            if (pan_hit) begin
                st_d.priv.w = 1'b0;
            end
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = !st_q.vld || out_ready;
    assign out_valid  = st_q.vld;
    assign out_priv   = st_q.priv;
    assign out_unpriv = st_q.unpriv;

    // Checks beside the logic

    a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_priv) && $stable(out_unpriv)));

    a_r8_priv_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ((out_priv & ~$past(base_priv)) == 3'b000));

    a_r8_unpriv_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ((out_unpriv & ~$past(base_unpriv)) == 3'b000));

    a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !priv_ov_en && !unpriv_ov_en && !pan_en)
        |=> (out_priv == $past(base_priv) && out_unpriv == $past(base_unpriv)));

    a_r6_el2_no_user: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && regime[1] && unpriv_ov_en && !indirect)
        |=> (out_unpriv == 3'b000));

    a_r10_pan_clears_w: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && pan_en && base_unpriv[0] && !unpriv_ov_en)
        |=> !out_priv[1]);

endmodule

// File: tb/s1_overlay_eval_test.sv
`timescale 1ns/1ps
module s1_overlay_eval_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        indirect = 1'b0;
    logic [3:0]  priv_ind_val = '0;
    logic [3:0]  unpriv_ind_val = '0;
    logic [2:0]  base_priv = '0;
    logic [2:0]  base_unpriv = '0;
    logic [2:0]  po_index = '0;
    logic [1:0]  regime = '0;
    logic        priv_ov_en = 1'b0;
    logic        unpriv_ov_en = 1'b0;
    logic [63:0] ov_reg_el0;
    logic [63:0] ov_reg_el1;
    logic [63:0] ov_reg_el2;
    logic        pan_en = 1'b0;
    logic        pan_ext_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_priv;
    logic [2:0]  out_unpriv;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // EL0 fields 7..0: 5 7 9 6 0 1 4 7 ; EL1: 3 5 F 8 4 2 1 7 ; EL2: C 0 7 2 6 5 7 1
    assign ov_reg_el0 = 64'h0000_0000_5796_0147;
    assign ov_reg_el1 = 64'h0000_0000_35F8_4217;
    assign ov_reg_el2 = 64'h0000_0000_C072_6571;

    s1_overlay_eval uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .indirect       (indirect),
        .priv_ind_val   (priv_ind_val),
        .unpriv_ind_val (unpriv_ind_val),
        .base_priv      (base_priv),
        .base_unpriv    (base_unpriv),
        .po_index       (po_index),
        .regime         (regime),
        .priv_ov_en     (priv_ov_en),
        .unpriv_ov_en   (unpriv_ov_en),
        .ov_reg_el0     (ov_reg_el0),
        .ov_reg_el1     (ov_reg_el1),
        .ov_reg_el2     (ov_reg_el2),
        .pan_en         (pan_en),
        .pan_ext_en     (pan_ext_en),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_priv       (out_priv),
        .out_unpriv     (out_unpriv)
    );

    // {ind, pind[4], uind[4], bp[3], bu[3], idx[3], rg[2], pe, ue, pan, pan3, exp_p[3], exp_u[3]}
    localparam int NV = 18;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0,4'h0,4'h0,3'd7,3'd7,3'd0,2'd0,1'b1,1'b1,1'b0,1'b0,3'd7,3'd7},
        {1'b0,4'h0,4'h0,3'd7,3'd7,3'd1,2'd0,1'b1,1'b1,1'b0,1'b0,3'd1,3'd2},
        {1'b0,4'h0,4'h0,3'd5,3'd7,3'd3,2'd0,1'b1,1'b1,1'b0,1'b0,3'd0,3'd0},
        {1'b0,4'h0,4'h0,3'd7,3'd3,3'd4,2'd0,1'b1,1'b1,1'b0,1'b0,3'd0,3'd2},
        {1'b0,4'h0,4'h0,3'd7,3'd6,3'd2,2'd1,1'b1,1'b1,1'b0,1'b0,3'd3,3'd0},
        {1'b0,4'h0,4'h0,3'd6,3'd7,3'd1,2'd2,1'b1,1'b1,1'b0,1'b0,3'd6,3'd0},
        {1'b1,4'h8,4'h3,3'd7,3'd7,3'd2,2'd0,1'b1,1'b1,1'b0,1'b0,3'd7,3'd1},
        {1'b1,4'h2,4'hA,3'd7,3'd7,3'd2,2'd0,1'b1,1'b1,1'b0,1'b0,3'd4,3'd7},
        {1'b0,4'h0,4'h0,3'd5,3'd3,3'd7,2'd2,1'b0,1'b0,1'b0,1'b0,3'd5,3'd3},
        {1'b0,4'h0,4'h0,3'd7,3'd4,3'd5,2'd0,1'b1,1'b0,1'b0,1'b0,3'd0,3'd4},
        {1'b0,4'h0,4'h0,3'd7,3'd1,3'd0,2'd0,1'b0,1'b0,1'b1,1'b0,3'd5,3'd1},
        {1'b0,4'h0,4'h0,3'd7,3'd4,3'd0,2'd0,1'b0,1'b0,1'b1,1'b0,3'd7,3'd4},
        {1'b0,4'h0,4'h0,3'd7,3'd4,3'd0,2'd0,1'b0,1'b0,1'b1,1'b1,3'd5,3'd4},
        {1'b0,4'h0,4'h0,3'd7,3'd7,3'd3,2'd0,1'b0,1'b1,1'b1,1'b1,3'd7,3'd0},
        {1'b0,4'h0,4'h0,3'd7,3'd3,3'd7,2'd2,1'b1,1'b1,1'b0,1'b0,3'd0,3'd0},
        {1'b0,4'h0,4'h0,3'd7,3'd7,3'd0,2'd3,1'b1,1'b1,1'b0,1'b0,3'd1,3'd0},
        {1'b1,4'h7,4'h8,3'd7,3'd7,3'd1,2'd0,1'b1,1'b1,1'b0,1'b0,3'd1,3'd7},
        {1'b1,4'h0,4'h0,3'd7,3'd7,3'd1,2'd0,1'b0,1'b1,1'b0,1'b0,3'd7,3'd2}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 2:          return "R3 R5";
            3, 9, 14:         return "R7";
            4, 5, 15:         return "R6";
            6, 7, 16, 17:     return "R4";
            8:                return "R9";
            default:          return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_vec(input int i);
        logic [29:0] v;
        v = VEC[i];
        indirect       = v[29];
        priv_ind_val   = v[28:25];
        unpriv_ind_val = v[24:21];
        base_priv      = v[20:18];
        base_unpriv    = v[17:15];
        po_index       = v[14:12];
        regime         = v[11:10];
        priv_ov_en     = v[9];
        unpriv_ov_en   = v[8];
        pan_en         = v[7];
        pan_ext_en     = v[6];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // Reset: R1
        repeat (3) @(posedge clk);
        #1;
        check("R1", "out_valid in reset", {3'b0, out_valid}, 4'd0);
        check("R1", "in_ready in reset", {3'b0, in_ready}, 4'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "out_valid after reset", {3'b0, out_valid}, 4'd0);
        check("R1", "in_ready after reset", {3'b0, in_ready}, 4'd1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            load_vec(i);
            in_valid  = 1'b1;
            out_ready = 1'b1;
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            check("R2", $sformatf("vec %0d valid", i), {3'b0, out_valid}, 4'd1);
            check(tag_of(i), $sformatf("vec %0d priv", i), {1'b0, out_priv}, {1'b0, VEC[i][5:3]});
            check(tag_of(i), $sformatf("vec %0d unpriv", i), {1'b0, out_unpriv}, {1'b0, VEC[i][2:0]});
            check("R8", $sformatf("vec %0d subset", i),
                  {1'b0, (out_priv & ~base_priv) | (out_unpriv & ~base_unpriv)}, 4'd0);
        end
        @(negedge clk);
        @(posedge clk);
        #1;
        check("R2", "valid drops when drained", {3'b0, out_valid}, 4'd0);

        // Back-pressure: R11
        @(negedge clk);
        load_vec(1);
        in_valid  = 1'b1;
        out_ready = 1'b0;
        @(posedge clk);
        #1;
        check("R2", "stall capture valid", {3'b0, out_valid}, 4'd1);
        @(negedge clk);
        load_vec(0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            check("R11", "held valid", {3'b0, out_valid}, 4'd1);
            check("R11", "in_ready low", {3'b0, in_ready}, 4'd0);
            check("R11", "held priv", {1'b0, out_priv}, 4'd1);
            check("R11", "held unpriv", {1'b0, out_unpriv}, 4'd2);
        end
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check("R2", "next result after release priv", {1'b0, out_priv}, 4'd7);
        check("R2", "next result after release unpriv", {1'b0, out_unpriv}, 4'd7);
        @(posedge clk);
        #1;
        check("R2", "idle after release", {3'b0, out_valid}, 4'd0);

        finish_run();
    end

endmodule